// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Flags

This block is a first-in first-out buffer for 9-bit words. It connects a producer and a consumer that run on unrelated clocks. Each port is gated by a pair of enables. Four active-low flags report the fill level. Empty and almost-empty are registered on the read clock. Full and almost-full are registered on the write clock. The write and read pointers cross between the domains as Gray code through two-stage synchronizers. Each side computes its flags from its own pointer and the synchronized copy of the other pointer.

The almost-empty and almost-full thresholds are held in two offset registers, and reset sets both to 7. The second write enable pin has two jobs. If the pin is low during reset, the block enters load mode. In load mode the pin works as a strobe, and the offset registers are written and read back through the normal data ports. If the pin is high during reset, it acts as a plain second write enable. Read data is registered. An output enable forces the data output to zero when it is low.

Top module: `dcfifo_pflag`

## Requirements
- R1: Reset (rst_n low on a clock edge) clears both pointers and drives empty_n=0, aempty_n=0, full_n=1 and afull_n=1.
- R2: Normal mode (wr_en_b_ld high during reset): a word is stored on a write-clock edge only when wr_en_a=1 and wr_en_b_ld=1. Words leave in the order they were stored.
- R3: full_n goes to 0 on the write edge that stores the DEPTH-th unread word. While full_n=0, write attempts are dropped and do not overwrite stored words.
- R4: A read takes place only when rd_en_a=1, rd_en_b=1 and empty_n=1. The word appears on rd_data after the read-clock edge that performs the read, and stays there until the next read.
- R5: empty_n goes to 0 on the read edge that removes the last word. While empty_n=0, reads leave rd_data and the read pointer unchanged.
- R6: afull_n is 0 exactly when the write side sees at least DEPTH minus the almost-full offset words stored. It is updated on write-clock edges.
- R7: aempty_n is 0 exactly when the read side sees at most the almost-empty offset words stored. It is updated on read-clock edges.
- R8: After reset, both offsets are 7.
- R9: If wr_en_b_ld is low during reset, the block enters load mode. The mode holds until the next reset.
- R10: In load mode, wr_en_a=1 with wr_en_b_ld=1 writes the low data bits to the offset registers and stores nothing in the FIFO. Successive loads alternate: almost-empty offset first, then almost-full offset. wr_en_a=1 with wr_en_b_ld=0 stores a FIFO word.
- R11: In load mode, rd_en_a=1 and rd_en_b=1 with wr_en_b_ld=1 return the offsets on rd_data, zero-extended, in the same alternating order. No FIFO word is consumed.
- R12: When out_en=0, rd_data is all zeros. When out_en=1, rd_data shows the read register.
- R13: A change in the other domain's pointer reaches the flags within four edges of the observing clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled by both clocks |
| wr_en_a | input | 1 | First write enable |
| wr_en_b_ld | input | 1 | Second write enable, or offset load strobe in load mode |
| wr_data | input | 9 | Write data / offset value |
| full_n | output | 1 | Full flag, active low |
| afull_n | output | 1 | Almost-full flag, active low |
| rd_en_a | input | 1 | First read enable |
| rd_en_b | input | 1 | Second read enable |
| out_en | input | 1 | Output enable for rd_data |
| rd_data | output | 9 | Read data / offset readback |
| empty_n | output | 1 | Empty flag, active low |
| aempty_n | output | 1 | Almost-empty flag, active low |

## Verification
Flags that depend only on the local pointer change on the same edge that moves that pointer. full_n and afull_n settle right after the storing write edge. empty_n, aempty_n and rd_data settle right after the consuming read edge. The bench drives on falling edges and samples on the next falling edge for these results. Any flag that depends on the far domain's pointer needs up to four edges of the observing clock. Before such a check, the bench waits six falling edges of each clock, so every compared value is already final.

// File: rtl/dcf_pkg.sv
// Shared word type and Gray-code helpers for the dual-clock FIFO.
// Assumes pointer widths of at most 16 bits.
package dcf_pkg;
    localparam int WORD_W = 9;
    typedef logic [WORD_W-1:0] word_t;

    // Convert a Gray value to binary by prefix XOR from the top bit.
    function automatic logic [15:0] gray2bin(input logic [15:0] g);
        logic [15:0] b;
        b[15] = g[15];
        for (int i = 14; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction
endpackage

// File: rtl/dcf_sync.sv
// Two-stage synchronizer for a Gray-coded pointer.
// Assumes at most one bit of d changes between capture edges.
module dcf_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Capture the foreign value, then retime it once more.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dcf_wr_ctrl.sv
// Write-side pointer and flag logic.
// Keeps a binary and a Gray write pointer. Full and almost-full are
// registered from the next pointer value and the synchronized read pointer.
// Assumes AW >= 2 and an almost-full offset below the depth.
module dcf_wr_ctrl #(
    parameter int AW = 6,
    parameter int OW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [AW:0]   rgray_s,
    input  logic [OW-1:0] afull_ofs,
    output logic [AW:0]   wbin,
    output logic [AW:0]   wgray,
    output logic          wr_fire,
    output logic          full_n,
    output logic          afull_n
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH_P = {1'b1, {AW{1'b0}}};

    logic [PW-1:0] wbin_nx, wgray_nx, rbin_s, fill_nx;
    logic          full_hit, afull_hit;

    // Next-state pointer and flag conditions.
    always_comb begin
        wr_fire   = wr_req & full_n;
        wbin_nx   = wbin + PW'(wr_fire);
        wgray_nx  = wbin_nx ^ (wbin_nx >> 1);
        rbin_s    = PW'(dcf_pkg::gray2bin(16'(rgray_s)));
        full_hit  = (wgray_nx == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
        fill_nx   = wbin_nx - rbin_s;
        afull_hit = (fill_nx >= (DEPTH_P - PW'(afull_ofs)));
    end

    // Register pointers and write-domain flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin    <= '0;
            wgray   <= '0;
            full_n  <= 1'b1;
            afull_n <= 1'b1;
        end else begin
            wbin    <= wbin_nx;
            wgray   <= wgray_nx;
            full_n  <= ~full_hit;
            afull_n <= ~afull_hit;
        end
    end

    // R3: a full FIFO keeps its write pointer.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |=> (wbin == $past(wbin)));
    // R6: full always implies almost-full.
    p_full_afull_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |-> !afull_n);
    // R3: the write side never sees more than DEPTH words.
    p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (PW'(wbin - rbin_s) <= DEPTH_P));
    // R1: flags leave reset deasserted.
    p_reset_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (full_n && afull_n));
endmodule

// File: rtl/dcf_rd_ctrl.sv
// Read-side pointer and flag logic.
// Keeps a binary and a Gray read pointer. Empty and almost-empty are
// registered from the next pointer value and the synchronized write pointer.
module dcf_rd_ctrl #(
    parameter int AW = 6,
    parameter int OW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic [AW:0]   wgray_s,
    input  logic [OW-1:0] aempty_ofs,
    output logic [AW:0]   rbin,
    output logic [AW:0]   rgray,
    output logic          rd_fire,
    output logic          empty_n,
    output logic          aempty_n
);
    localparam int PW = AW + 1;

    logic [PW-1:0] rbin_nx, rgray_nx, wbin_s, level_nx;
    logic          empty_hit, aempty_hit;

    // Next-state pointer and flag conditions.
    always_comb begin
        rd_fire    = rd_req & empty_n;
        rbin_nx    = rbin + PW'(rd_fire);
        rgray_nx   = rbin_nx ^ (rbin_nx >> 1);
        wbin_s     = PW'(dcf_pkg::gray2bin(16'(wgray_s)));
        empty_hit  = (rgray_nx == wgray_s);
        level_nx   = wbin_s - rbin_nx;
        aempty_hit = (level_nx <= PW'(aempty_ofs));
    end

    // Register pointers and read-domain flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin     <= '0;
            rgray    <= '0;
            empty_n  <= 1'b0;
            aempty_n <= 1'b0;
        end else begin
            rbin     <= rbin_nx;
            rgray    <= rgray_nx;
            empty_n  <= ~empty_hit;
            aempty_n <= ~aempty_hit;
        end
    end

    // R5: an empty FIFO keeps its read pointer.
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_n |=> (rbin == $past(rbin)));
    // R7: empty always implies almost-empty.
    p_empty_aempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_n |-> !aempty_n);
    // R1: flags leave reset asserted.
    p_reset_flags_r1b: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!empty_n && !aempty_n));
endmodule

// File: rtl/dcfifo_pflag.sv
// Dual-clock FIFO top: storage, enable decode, mode latches, offset
// registers, read-data register and the pointer crossings.
// Assumes the offsets are loaded or read back while the FIFO is idle,
// and that wr_en_b_ld is steady around a readback. The offsets are
// quasi-static settings, so the read side uses them without resynchronizing.
module dcfifo_pflag #(
    parameter int AW = 6
) (
    input  logic                     wr_clk,
    input  logic                     rd_clk,
    input  logic                     rst_n,
    input  logic                     wr_en_a,
    input  logic                     wr_en_b_ld,
    input  logic [dcf_pkg::WORD_W-1:0] wr_data,
    output logic                     full_n,
    output logic                     afull_n,
    input  logic                     rd_en_a,
    input  logic                     rd_en_b,
    input  logic                     out_en,
    output logic [dcf_pkg::WORD_W-1:0] rd_data,
    output logic                     empty_n,
    output logic                     aempty_n
);
    import dcf_pkg::*;

    localparam int DEPTH = 1 << AW;
    localparam int OW    = (AW < WORD_W) ? AW : WORD_W;

    word_t          mem [DEPTH];
    word_t          rd_q;
    logic [AW:0]    wbin, wgray, rbin, rgray, wgray_s, rgray_s;
    logic [OW-1:0]  aempty_ofs, afull_ofs;
    logic           mode_ld_w, mode_ld_r, wsel, rsel;
    logic           fifo_wr_req, ofs_wr, wr_fire;
    logic           fifo_rd_req, ofs_rd, rd_fire;

    // Decode the write enables according to the latched mode.
    always_comb begin
        fifo_wr_req = mode_ld_w ? (wr_en_a & ~wr_en_b_ld) : (wr_en_a & wr_en_b_ld);
        ofs_wr      = mode_ld_w & wr_en_a & wr_en_b_ld;
    end

    // Decode the read enables according to the latched mode.
    always_comb begin
        fifo_rd_req = rd_en_a & rd_en_b & ~(mode_ld_r & wr_en_b_ld);
        ofs_rd      = rd_en_a & rd_en_b & mode_ld_r & wr_en_b_ld;
    end

    // Latch the mode during reset and write the offset registers in order.
    always_ff @(posedge wr_clk) begin
        if (!rst_n) begin
            mode_ld_w  <= ~wr_en_b_ld;
            aempty_ofs <= OW'(7);
            afull_ofs  <= OW'(7);
            wsel       <= 1'b0;
        end else if (ofs_wr) begin
            if (wsel) afull_ofs  <= wr_data[OW-1:0];
            else      aempty_ofs <= wr_data[OW-1:0];
            wsel <= ~wsel;
        end
    end

    // Store an accepted word at the write pointer.
    always_ff @(posedge wr_clk) begin
        if (wr_fire) mem[wbin[AW-1:0]] <= wr_data;
    end

    // Latch the mode in the read domain; load the read register from memory or the offsets.
    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            mode_ld_r <= ~wr_en_b_ld;
            rd_q      <= '0;
            rsel      <= 1'b0;
        end else if (rd_fire) begin
            rd_q <= mem[rbin[AW-1:0]];
        end else if (ofs_rd) begin
            rd_q <= rsel ? WORD_W'(afull_ofs) : WORD_W'(aempty_ofs);
            rsel <= ~rsel;
        end
    end

    // Gate the output data.
    always_comb rd_data = out_en ? rd_q : '0;

    dcf_sync #(.W(AW + 1)) u_sync_w2r (
        .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s));

    dcf_sync #(.W(AW + 1)) u_sync_r2w (
        .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s));

    dcf_wr_ctrl #(.AW(AW), .OW(OW)) u_wr (
        .clk(wr_clk), .rst_n(rst_n), .wr_req(fifo_wr_req), .rgray_s(rgray_s),
        .afull_ofs(afull_ofs), .wbin(wbin), .wgray(wgray), .wr_fire(wr_fire),
        .full_n(full_n), .afull_n(afull_n));

    dcf_rd_ctrl #(.AW(AW), .OW(OW)) u_rd (
        .clk(rd_clk), .rst_n(rst_n), .rd_req(fifo_rd_req), .wgray_s(wgray_s),
        .aempty_ofs(aempty_ofs), .rbin(rbin), .rgray(rgray), .rd_fire(rd_fire),
        .empty_n(empty_n), .aempty_n(aempty_n));

    // R10: an offset load never stores a FIFO word.
    p_load_no_store_r10: assert property (@(posedge wr_clk) disable iff (!rst_n)
        ofs_wr |-> !wr_fire);
    // R11: an offset readback never consumes a FIFO word.
    p_readback_no_pop_r11: assert property (@(posedge rd_clk) disable iff (!rst_n)
        ofs_rd |-> !rd_fire);
    // R12: a disabled output is zero.
    p_oe_zero_r12: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !out_en |-> (rd_data == '0));
endmodule

// File: tb/dcfifo_pflag_tb.sv
module dcfifo_pflag_tb;
    localparam int DEPTH = 64;

    logic       wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
    logic       wr_en_a = 1'b0, wr_en_b_ld = 1'b1, rd_en_a = 1'b0, rd_en_b = 1'b0, out_en = 1'b1;
    logic [8:0] wr_data = '0;
    logic [8:0] rd_data;
    logic       full_n, afull_n, empty_n, aempty_n;
    int         checks = 0, fails = 0;
    logic [8:0] q;

    always #2 wr_clk = ~wr_clk;   // 250 MHz write clock
    always #3 rd_clk = ~rd_clk;   // unrelated read clock

    dcfifo_pflag #(.AW(6)) u_dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en_a(wr_en_a),
        .wr_en_b_ld(wr_en_b_ld), .wr_data(wr_data), .full_n(full_n), .afull_n(afull_n),
        .rd_en_a(rd_en_a), .rd_en_b(rd_en_b), .out_en(out_en), .rd_data(rd_data),
        .empty_n(empty_n), .aempty_n(aempty_n));

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    task automatic do_reset(input logic load_mode);
        rst_n = 1'b0;
        wr_en_b_ld = ~load_mode;
        repeat (4) @(negedge wr_clk);
        repeat (4) @(negedge rd_clk);
        @(negedge wr_clk);
        rst_n = 1'b1;
        wr_en_b_ld = 1'b0;
        repeat (3) @(negedge rd_clk);
    endtask

    task automatic settle();
        repeat (6) @(negedge rd_clk);
        repeat (6) @(negedge wr_clk);
    endtask

    task automatic push(input logic [8:0] d, input logic a, input logic b);
        @(negedge wr_clk);
        wr_en_a = a; wr_en_b_ld = b; wr_data = d;
        @(negedge wr_clk);
        wr_en_a = 1'b0; wr_en_b_ld = 1'b0;
    endtask

    task automatic pop(input logic a, input logic b, input logic ld, output logic [8:0] d);
        @(negedge rd_clk);
        rd_en_a = a; rd_en_b = b; wr_en_b_ld = ld;
        @(negedge rd_clk);
        rd_en_a = 1'b0; rd_en_b = 1'b0; wr_en_b_ld = 1'b0;
        d = rd_data;
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        chk(empty_n, 0, "R1 empty_n");
        chk(aempty_n, 0, "R1 aempty_n");
        chk(full_n, 1, "R1 full_n");
        chk(afull_n, 1, "R1 afull_n");
    endtask

    task automatic t_basic();
        push(9'h1A5, 1, 1); push(9'h0F0, 1, 1); push(9'h155, 1, 1);
        settle();
        chk(empty_n, 1, "R13 empty_n after crossing");
        pop(1, 1, 0, q); chk(q, 9'h1A5, "R2 order word0");
        pop(1, 1, 0, q); chk(q, 9'h0F0, "R4 order word1");
        pop(1, 1, 0, q); chk(q, 9'h155, "R4 order word2");
        chk(empty_n, 0, "R5 empty on last read edge");
    endtask

    task automatic t_gating();
        push(9'h011, 1, 0); push(9'h022, 0, 1);
        settle();
        chk(empty_n, 0, "R2 single write enable ignored");
        push(9'h033, 1, 1);
        settle();
        pop(1, 0, 0, q);
        chk(q, 9'h155, "R4 single read enable keeps data");
        chk(empty_n, 1, "R4 single read enable keeps word");
        pop(1, 1, 0, q); chk(q, 9'h033, "R4 two-enable read");
        pop(1, 1, 0, q); chk(q, 9'h033, "R5 read when empty holds data");
        chk(empty_n, 0, "R5 stays empty");
        push(9'h044, 1, 1);
        settle();
        pop(1, 1, 0, q); chk(q, 9'h044, "R5 pointer not advanced by empty read");
    endtask

    task automatic t_fill();
        settle();
        for (int i = 0; i < 56; i++) push(9'(i), 1, 1);
        chk(afull_n, 1, "R6 R8 below almost-full at 56");
        push(9'd56, 1, 1);
        chk(afull_n, 0, "R6 R8 almost-full at 57");
        for (int i = 57; i < 63; i++) push(9'(i), 1, 1);
        chk(full_n, 1, "R3 not full at 63");
        push(9'd63, 1, 1);
        chk(full_n, 0, "R3 full at 64");
        push(9'h1FF, 1, 1); push(9'h1FE, 1, 1);
        settle();
        for (int i = 0; i < DEPTH; i++) begin
            pop(1, 1, 0, q);
            chk(q, i, "R3 stored word survives overflow attempt");
        end
        chk(empty_n, 0, "R3 no extra word after overflow attempt");
        for (int i = 0; i < 8; i++) push(9'(8'h80 + i), 1, 1);
        settle();
        chk(aempty_n, 1, "R7 above almost-empty at 8");
        pop(1, 1, 0, q);
        chk(aempty_n, 0, "R7 R8 almost-empty at 7");
        for (int i = 0; i < 7; i++) pop(1, 1, 0, q);
        chk(q, 9'h87, "R2 last word of burst");
    endtask

    task automatic t_oe();
        push(9'h0AB, 1, 1);
        settle();
        out_en = 1'b0;
        pop(1, 1, 0, q);
        chk(q, 0, "R12 output disabled");
        out_en = 1'b1;
        #1;
        chk(rd_data, 9'h0AB, "R12 output enabled");
    endtask

    task automatic t_load();
        do_reset(1'b1);
        pop(1, 1, 1, q); chk(q, 7, "R8 R11 default almost-empty offset");
        pop(1, 1, 1, q); chk(q, 7, "R8 R11 default almost-full offset");
        push(9'd3, 1, 1); push(9'd10, 1, 1);
        settle();
        chk(empty_n, 0, "R9 R10 offset load stores no word");
        pop(1, 1, 1, q); chk(q, 3, "R10 R11 almost-empty offset loaded first");
        pop(1, 1, 1, q); chk(q, 10, "R10 R11 almost-full offset loaded second");
        for (int i = 0; i < 4; i++) push(9'(9'h100 + i), 1, 0);
        settle();
        chk(aempty_n, 1, "R7 R10 above new offset at 4");
        pop(1, 1, 0, q);
        chk(q, 9'h100, "R10 load-mode FIFO write");
        chk(aempty_n, 0, "R7 new offset at 3");
        settle();
        for (int i = 0; i < 50; i++) push(9'(i), 1, 0);
        chk(afull_n, 1, "R6 below new threshold at 53");
        push(9'h0, 1, 0);
        chk(afull_n, 0, "R6 new threshold at 54");
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_gating();
        t_fill();
        t_oe();
        t_load();
        summary();
        $finish;
    end
endmodule